// File: doc/BRIEF.md
# Banked Internal Data RAM with Upward Stack

This block holds the 128 bytes of general-purpose internal data RAM of a small microcontroller core, together with the working-register bank selector and the stack pointer. The RAM is reached in three ways. Direct-address ports use an 8-bit address. Named-register ports use a 3-bit register number, which is mapped into RAM through the active bank. Push and pop strobes move bytes between a direct-address operand and the stack.

The bottom 32 bytes hold four banks of eight working registers. Bytes 20h to 2Fh, the bit-addressable zone, stay reachable as ordinary bytes. 30h to 7Fh is free scratch space. Addresses from 80h upward belong to the peripheral-register space and are not stored here. The stack grows upward through the same RAM, and software may relocate it by loading the pointer.

Top module: `idata_bank_ram`

## Requirements
- R1: A direct write with an address below 80h stores the byte, and a direct read returns it. A direct write at 80h or above changes no RAM byte. A direct read at 80h or above returns 00h.
- R2: Named register n (reg_idx = n) maps to RAM address bank×8 + n. A named access and a direct access to that address see the same byte.
- R3: The active bank resets to 0. It takes bank_in on a clock edge with bank_load high and holds its value otherwise. bank_in[1] is the high bank bit and bank_in[0] is the low bank bit.
- R4: The stack pointer resets to 07h. sp_load loads sp_in on the next edge. All RAM bytes reset to 00h.
- R5: A push increments the pointer, then writes the byte found at direct address stk_addr into RAM at the new pointer. A source at 80h or above supplies 00h. The first push after reset therefore lands at 08h.
- R6: A pop presents the byte at the current pointer on pop_data in the same cycle. It writes that byte to direct address stk_addr, then decrements the pointer.
- R7: The pointer wraps modulo 256. stk_oor is high in a cycle where a push targets a new pointer of 80h or above, or where a pop reads at a pointer of 80h or above. In such a cycle the stack's RAM write is suppressed and pop_data reads 00h. A pop whose destination stk_addr is 80h or above also writes nothing.
- R8: When a read port addresses the byte being written in the same cycle, it returns the new value (write-first).
- R9: At most one RAM write happens per cycle, chosen in the priority order push, pop, direct write, named write. When push and pop are both high, only the push acts. sp_load overrides both push and pop, which are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_load | input | 1 | Load the bank selector |
| bank_in | input | 2 | New bank number (high bit, low bit) |
| cur_bank | output | 2 | Active bank |
| reg_idx | input | 3 | Named register number |
| reg_we | input | 1 | Named register write strobe |
| reg_wdata | input | 8 | Named register write data |
| reg_rdata | output | 8 | Named register read data |
| dir_addr | input | 8 | Direct address |
| dir_we | input | 1 | Direct write strobe |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| stk_addr | input | 8 | Direct operand of push (source) or pop (destination) |
| pop_data | output | 8 | Byte at the current pointer |
| sp_load | input | 1 | Load the stack pointer |
| sp_in | input | 8 | New stack pointer value |
| sp | output | 8 | Stack pointer |
| stk_oor | output | 1 | Stack access outside the RAM |

## Verification
The assertions assume that every strobe and address is driven to a known value in every cycle after reset, and that reset is applied synchronously for at least one edge. They also rely on the priority of R9 to resolve colliding strobes. The stimulus drives all inputs from the bench at the falling edge, so no input is ever left floating. The random pointer loads are biased toward values below 80h, so that push and pop mostly stay inside the RAM. A minority of loads and directed cases still reach 7Fh, 80h and FFh, to cover the out-of-range flag and the wrap.

// File: rtl/idata_bank_ram.sv
module idata_bank_ram #(
  parameter int          DW      = 8,
  parameter int          AW      = 8,
  parameter int          RIW     = 3,
  parameter int          BW      = 2,
  parameter logic [7:0]  SP_INIT = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_load,
  input  logic [BW-1:0] bank_in,
  output logic [BW-1:0] cur_bank,
  input  logic [RIW-1:0] reg_idx,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [AW-1:0] dir_addr,
  input  logic          dir_we,
  input  logic [DW-1:0] dir_wdata,
  output logic [DW-1:0] dir_rdata,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] stk_addr,
  output logic [DW-1:0] pop_data,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_in,
  output logic [AW-1:0] sp,
  output logic          stk_oor
);
  localparam int WORDS = 1 << (AW - 1);
  localparam int PADW  = AW - BW - RIW;

  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] sp_q;
  logic [BW-1:0] bank_q;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  wire           do_push  = push & ~sp_load;
  wire           do_pop   = pop & ~push & ~sp_load;
  wire [AW-1:0]  sp_inc   = sp_q + 1'b1;
  wire [AW-1:0]  sp_dec   = sp_q - 1'b1;
  wire [AW-1:0]  reg_addr = {{PADW{1'b0}}, bank_q, reg_idx};
  wire [DW-1:0]  push_src = stk_addr[AW-1] ? '0 : mem[stk_addr[AW-2:0]];
  wire [DW-1:0]  reg_mem  = mem[reg_addr[AW-2:0]];
  wire [DW-1:0]  dir_mem  = mem[dir_addr[AW-2:0]];

  assign pop_data = sp_q[AW-1] ? '0 : mem[sp_q[AW-2:0]];
  assign stk_oor  = (do_push & sp_inc[AW-1]) | (do_pop & sp_q[AW-1]);
  assign sp       = sp_q;
  assign cur_bank = bank_q;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    if (do_push) begin
      wr_en   = ~sp_inc[AW-1];
      wr_addr = sp_inc;
      wr_data = push_src;
    end else if (do_pop) begin
      wr_en   = ~sp_q[AW-1] & ~stk_addr[AW-1];
      wr_addr = stk_addr;
      wr_data = pop_data;
    end else if (dir_we) begin
      wr_en   = ~dir_addr[AW-1];
      wr_addr = dir_addr;
      wr_data = dir_wdata;
    end else if (reg_we) begin
      wr_en   = 1'b1;
      wr_addr = reg_addr;
      wr_data = reg_wdata;
    end
  end

  assign dir_rdata = dir_addr[AW-1] ? '0 :
                     (wr_en && wr_addr == dir_addr) ? wr_data : dir_mem;
  assign reg_rdata = (wr_en && wr_addr == reg_addr) ? wr_data : reg_mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr[AW-2:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sp_q <= SP_INIT;
    else if (sp_load)  sp_q <= sp_in;
    else if (do_push)  sp_q <= sp_inc;
    else if (do_pop)   sp_q <= sp_dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         bank_q <= '0;
    else if (bank_load) bank_q <= bank_in;
  end

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(cur_bank));
  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sp_load) |=> sp == $past(sp) + 8'd1);
  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !sp_load) |=> sp == $past(sp) - 8'd1);
  p_top_push_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sp_load && sp == 8'h7F) |-> stk_oor);
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> sp == $past(sp_in));
  p_high_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_addr[AW-1] |-> dir_rdata == '0);
  p_dir_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !push && !pop && !dir_addr[AW-1]) |=>
      mem[$past(dir_addr[AW-2:0])] == $past(dir_wdata));
  p_write_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !push && !pop && !dir_addr[AW-1]) |-> dir_rdata == dir_wdata);
endmodule

// File: tb/idata_bank_ram_bench.sv
module idata_bank_ram_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n;
  logic       bank_load;
  logic [1:0] bank_in, cur_bank;
  logic [2:0] reg_idx;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] dir_addr, dir_wdata, dir_rdata;
  logic       dir_we, push, pop, sp_load, stk_oor;
  logic [7:0] stk_addr, pop_data, sp_in, sp;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [128];
  logic [7:0] msp;
  logic [1:0] mbank;

  always #(CLK_PERIOD/2) clk = ~clk;

  idata_bank_ram u_idata_bank_ram (.*);

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input logic [7:0] a);
    return a[7] ? 8'h00 : m[a[6:0]];
  endfunction

  task automatic idle();
    bank_load = 0; bank_in = 0; reg_idx = 0; reg_we = 0; reg_wdata = 0;
    dir_addr = 0; dir_we = 0; dir_wdata = 0; push = 0; pop = 0;
    stk_addr = 0; sp_load = 0; sp_in = 0;
  endtask

  task automatic step();
    logic       we, dp, dq, oor;
    logic [7:0] wa, wd, e_dir, e_reg, e_pop, nsp, ra;
    #1;
    dp = push & ~sp_load;
    dq = pop & ~push & ~sp_load;
    ra = {3'b000, mbank, reg_idx};
    e_pop = rd(msp);
    we = 0; wa = 0; wd = 0;
    if (dp) begin we = ~(msp + 8'd1) >> 7; wa = msp + 8'd1; wd = rd(stk_addr); we = ~wa[7]; end
    else if (dq) begin we = ~msp[7] & ~stk_addr[7]; wa = stk_addr; wd = e_pop; end
    else if (dir_we) begin we = ~dir_addr[7]; wa = dir_addr; wd = dir_wdata; end
    else if (reg_we) begin we = 1; wa = ra; wd = reg_wdata; end
    oor = (dp & wa[7]) | (dq & msp[7]);
    e_dir = dir_addr[7] ? 8'h00 : (we && wa == dir_addr) ? wd : m[dir_addr[6:0]];
    e_reg = (we && wa == ra) ? wd : m[ra[6:0]];
    check(dir_rdata === e_dir, (we && wa == dir_addr) ? "R8" : "R1", dir_rdata, e_dir);
    check(reg_rdata === e_reg, "R2", reg_rdata, e_reg);
    check(pop_data === e_pop, "R6", pop_data, e_pop);
    check(stk_oor === oor, "R7", {7'd0, stk_oor}, {7'd0, oor});
    nsp = sp_load ? sp_in : dp ? msp + 8'd1 : dq ? msp - 8'd1 : msp;
    @(posedge clk);
    if (we) m[wa[6:0]] = wd;
    msp = nsp;
    if (bank_load) mbank = bank_in;
    #1;
    check(sp === msp, sp_load ? "R9" : dp ? "R5" : dq ? "R6" : "R4", sp, msp);
    check(cur_bank === mbank, "R3", {6'd0, cur_bank}, {6'd0, mbank});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    msp = 8'h07; mbank = 2'd0;
    #1;
    check(sp === 8'h07, "R4", sp, 8'h07);
    check(cur_bank === 2'd0, "R3", {6'd0, cur_bank}, 8'h00);
    check(dir_rdata === 8'h00, "R4", dir_rdata, 8'h00);

    // direct write then push it: first push lands at 08h
    idle(); dir_we = 1; dir_addr = 8'h30; dir_wdata = 8'hA5; step();
    idle(); push = 1; stk_addr = 8'h30; step();
    idle(); dir_addr = 8'h08; #1;
    check(dir_rdata === 8'hA5, "R5", dir_rdata, 8'hA5);
    // bank 1 register R0 is address 08h
    idle(); bank_load = 1; bank_in = 2'b01; step();
    idle(); reg_idx = 0; #1;
    check(reg_rdata === 8'hA5, "R2", reg_rdata, 8'hA5);
    // pop into 40h
    idle(); pop = 1; stk_addr = 8'h40; step();
    idle(); dir_addr = 8'h40; #1;
    check(dir_rdata === 8'hA5, "R6", dir_rdata, 8'hA5);
    // high address write ignored
    idle(); dir_we = 1; dir_addr = 8'hC0; dir_wdata = 8'h11; step();
    idle(); dir_addr = 8'h40; #1;
    check(dir_rdata === 8'hA5, "R1", dir_rdata, 8'hA5);
    // push at 7Fh flagged, wrap at FFh
    idle(); sp_load = 1; sp_in = 8'h7F; step();
    idle(); push = 1; stk_addr = 8'h40; step();
    idle(); sp_load = 1; sp_in = 8'hFF; step();
    idle(); push = 1; stk_addr = 8'h40; step();
    check(sp === 8'h00, "R7", sp, 8'h00);
    // push and pop together: push only
    idle(); push = 1; pop = 1; stk_addr = 8'h30; step();

    for (int k = 0; k < 4000; k++) begin
      idle();
      bank_load = ($urandom % 8) == 0;
      bank_in   = 2'($urandom);
      reg_idx   = 3'($urandom);
      reg_we    = ($urandom % 3) == 0;
      reg_wdata = 8'($urandom);
      dir_addr  = ($urandom % 5 == 0) ? 8'($urandom) : {1'b0, 7'($urandom)};
      dir_we    = ($urandom % 3) == 0;
      dir_wdata = 8'($urandom);
      push      = ($urandom % 4) == 0;
      pop       = ($urandom % 4) == 0;
      stk_addr  = ($urandom % 6 == 0) ? 8'($urandom) : {1'b0, 7'($urandom)};
      sp_load   = ($urandom % 10) == 0;
      sp_in     = ($urandom % 4 == 0) ? 8'($urandom) : {2'b00, 6'($urandom)} + 8'h20;
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule